// File: doc/BRIEF.md
# Balanced Ternary Word Encoder

This block turns 20-bit data words into a stream of two-trit symbols for a three-level serial line while keeping the line's DC level close to zero. The word gets a cleared bit below its LSB, which gives seven 3-bit groups. The block tries all eight 3-bit XOR masks on those groups, one mask per cycle. For each mask it forms the level sum of the resulting symbols and adds the running disparity carried over from earlier words. It keeps the mask that leaves the smallest absolute disparity.

A word goes out as eight symbols. The chosen mask comes first and the seven masked groups follow. A group that matches the group just before it is replaced by the quiet symbol (0,0), which tells the receiver to reuse the previous group. The number of such repeats in a row is limited so that the line keeps enough transitions.

Words enter through a valid/ready handshake. The search for the next word runs while the current word is still being sent, so the line rarely has to wait.

Top module: `tern_balance_enc`

## Requirements
- R1: Each trit uses two bits: 00 is 0, 10 is +, 01 is −. A symbol is 4 bits, with bits [3:2] holding the first trit and bits [1:0] the second. Groups map to symbols as follows: 000→(−,0), 001→(0,−), 010→(+,+), 011→(−,−), 100→(+,0), 101→(0,+), 110→(−,+), 111→(+,−).
- R2: The word is extended to 21 bits with a 0 below bit 0. Groups go out most significant first: the first group is data bits 19:17 and the last group is {bit 1, bit 0, 0}.
- R3: Every word is sent as exactly eight symbols. The first is the mask symbol, encoded with the R1 table. It is never replaced by the quiet symbol, and sym_first_o is high only while it is on the output.
- R4: Each group is XORed with the chosen mask before it is mapped to a symbol.
- R5: A group (after masking) that equals the group before it is sent as 0000. The first group of a word is never replaced.
- R6: At most two quiet symbols can occur in a row. A third consecutive match is sent as its real code, and the repeat count starts again after it.
- R7: Group weights are −1 for 000 and 001, +2 for 010, −2 for 011, +1 for 100 and 101, and 0 for 110 and 111. A quiet symbol weighs 0 and the mask symbol is not counted. The chosen mask minimises |running disparity + sum of weights|, and a tie goes to the lower mask.
- R8: The running disparity is 0 after reset. After each word it becomes the chosen total, clamped to ±(2^(RD_W−1)−1), and the next word is searched against that value.
- R9: A word is taken on a clock edge where word_valid_i and word_ready_o are both high. word_ready_o then stays low for the next eight cycles while the search runs.
- R10: In reset, word_ready_o is high and sym_valid_o is low.
- R11: Words are sent in the order they were accepted, with no symbol lost. A word's symbols start only after its search has finished, and the search for the next word may run while the current word is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid_i | input | 1 | Input word is present |
| word_data_i | input | 20 | Data word |
| word_ready_o | output | 1 | Encoder can take a word |
| sym_valid_o | output | 1 | sym_o carries a symbol this cycle |
| sym_first_o | output | 1 | Current symbol is a word's mask symbol |
| sym_o | output | 4 | Two trits, first trit in [3:2] |

## Verification
Two functions can fall in the same clock edge: the search unit hands a finished word to the serializer while it accepts the next input word, and at that edge the serializer also moves from one word's last symbol to the next word's mask symbol. The bench provokes this by holding word_valid_i high across a burst of words, so that every acceptance after the first lines up with a handoff. It then compares the full symbol stream, including the first-symbol markers, against a model of the requirements. A dropped, repeated or misordered symbol, or a running disparity that was updated too late, shows up as a mismatch at a named position in the stream.

// File: rtl/tern_pkg.sv
// Shared constants and group-to-symbol functions of the ternary word encoder.
// Assumes 3-bit groups; the symbol table and weights are fixed by the line code.
package tern_pkg;
    localparam int GRP_W = 3;
    localparam logic [1:0] T_Z = 2'b00;
    localparam logic [1:0] T_P = 2'b10;
    localparam logic [1:0] T_N = 2'b01;

    // Map one 3-bit group to its two-trit symbol, first trit in the upper pair.
    function automatic logic [3:0] grp_symbol(input logic [GRP_W-1:0] g);
        case (g)
            3'b000:  return {T_N, T_Z};
            3'b001:  return {T_Z, T_N};
            3'b010:  return {T_P, T_P};
            3'b011:  return {T_N, T_N};
            3'b100:  return {T_P, T_Z};
            3'b101:  return {T_Z, T_P};
            3'b110:  return {T_N, T_P};
            default: return {T_P, T_N};
        endcase
    endfunction

    // Net line level of one group's symbol.
    function automatic logic signed [2:0] grp_weight(input logic [GRP_W-1:0] g);
        case (g)
            3'b000, 3'b001: return -3'sd1;
            3'b010:         return 3'sd2;
            3'b011:         return -3'sd2;
            3'b100, 3'b101: return 3'sd1;
            default:        return 3'sd0;
        endcase
    endfunction
endpackage

// File: rtl/tern_repeat_map.sv
// Marks which groups of a word go out as the quiet (repeat) symbol.
// Assumes the word arrives already padded-free; pads one zero bit below the LSB.
// Masking does not change group equality, so one map serves all eight masks.
module tern_repeat_map import tern_pkg::*; #(
    parameter int N_GROUPS  = 7,
    parameter int RUN_LIMIT = 2
) (
    input  logic [N_GROUPS*GRP_W-2:0] word_i,
    output logic [N_GROUPS-1:0]       rep_o
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 2);

    logic [N_GROUPS*GRP_W-1:0] pad;
    logic [GRP_W-1:0]          grp [N_GROUPS];
    logic [RUN_W-1:0]          run;

    assign pad = {word_i, 1'b0};

    for (genvar i = 0; i < N_GROUPS; i++) begin : g_split
        assign grp[i] = pad[(N_GROUPS-1-i)*GRP_W +: GRP_W];
    end

    // Walk the groups in send order, substituting matches up to the run limit.
    always_comb begin
        rep_o = '0;
        run   = '0;
        for (int i = 1; i < N_GROUPS; i++) begin
            if (grp[i] == grp[i-1] && run < RUN_W'(RUN_LIMIT)) begin
                rep_o[i] = 1'b1;
                run      = run + 1'b1;
            end else begin
                run = '0;
            end
        end
    end
endmodule

// File: rtl/tern_cand_eval.sv
// Computes the disparity total of one mask candidate and its magnitude.
// Assumes RD_W is wide enough that 2*N_GROUPS fits beside the carried disparity.
module tern_cand_eval import tern_pkg::*; #(
    parameter int N_GROUPS = 7,
    parameter int RD_W     = 6,
    localparam int TOT_W   = RD_W + 1
) (
    input  logic [N_GROUPS*GRP_W-2:0] word_i,
    input  logic [GRP_W-1:0]          mask_i,
    input  logic [N_GROUPS-1:0]       rep_i,
    input  logic signed [RD_W-1:0]    rd_i,
    output logic signed [TOT_W-1:0]   total_o,
    output logic [TOT_W-1:0]          mag_o
);
    logic [N_GROUPS*GRP_W-1:0] pad;
    logic signed [TOT_W-1:0]   wt [N_GROUPS];

    assign pad = {word_i, 1'b0};

    for (genvar i = 0; i < N_GROUPS; i++) begin : g_wt
        assign wt[i] = rep_i[i] ? '0
                     : TOT_W'(grp_weight(pad[(N_GROUPS-1-i)*GRP_W +: GRP_W] ^ mask_i));
    end

    // Add the carried disparity to every group weight.
    always_comb begin
        total_o = TOT_W'(rd_i);
        for (int i = 0; i < N_GROUPS; i++) total_o = total_o + wt[i];
    end

    // Absolute value used for candidate ranking.
    assign mag_o = total_o[TOT_W-1] ? $unsigned(-total_o) : $unsigned(total_o);
endmodule

// File: rtl/tern_mask_search.sv
// Accepts a word, tries the eight masks over eight cycles, keeps the best one
// and updates the running disparity. Holds the result until the serializer takes it.
module tern_mask_search import tern_pkg::*; #(
    parameter int N_GROUPS  = 7,
    parameter int RUN_LIMIT = 2,
    parameter int RD_W      = 6,
    localparam int WORD_W   = N_GROUPS*GRP_W - 1,
    localparam int TOT_W    = RD_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid_i,
    input  logic [WORD_W-1:0]   in_data_i,
    output logic                in_ready_o,
    output logic                res_valid_o,
    input  logic                res_take_i,
    output logic [WORD_W-1:0]   res_word_o,
    output logic [GRP_W-1:0]    res_mask_o,
    output logic [N_GROUPS-1:0] res_rep_o
);
    localparam logic signed [TOT_W-1:0] RD_HI = TOT_W'(2**(RD_W-1) - 1);
    localparam logic signed [TOT_W-1:0] RD_LO = -RD_HI;

    logic                    busy, done, accept;
    logic [GRP_W-1:0]        cnt, best_mask;
    logic [WORD_W-1:0]       word_q;
    logic signed [RD_W-1:0]  rd_q;
    logic signed [TOT_W-1:0] cand_tot, best_tot, win_tot;
    logic [TOT_W-1:0]        cand_mag, best_mag;
    logic                    cand_better;

    tern_repeat_map #(.N_GROUPS(N_GROUPS), .RUN_LIMIT(RUN_LIMIT)) rep_i (
        .word_i(word_q), .rep_o(res_rep_o));

    tern_cand_eval #(.N_GROUPS(N_GROUPS), .RD_W(RD_W)) eval_i (
        .word_i(word_q), .mask_i(cnt), .rep_i(res_rep_o), .rd_i(rd_q),
        .total_o(cand_tot), .mag_o(cand_mag));

    assign in_ready_o  = !busy && (!done || res_take_i);
    assign accept      = in_valid_i && in_ready_o;
    assign res_valid_o = done;
    assign res_word_o  = word_q;
    assign res_mask_o  = best_mask;
    assign cand_better = (cnt == '0) || (cand_mag < best_mag);
    assign win_tot     = cand_better ? cand_tot : best_tot;

    // Sequence the search, track the strict best, and carry the disparity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; done <= 1'b0; cnt <= '0; word_q <= '0;
            best_mask <= '0; best_mag <= '0; best_tot <= '0; rd_q <= '0;
        end else begin
            if (done && res_take_i) done <= 1'b0;
            if (accept) begin
                word_q <= in_data_i;
                busy   <= 1'b1;
                cnt    <= '0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cand_better) begin
                    best_mask <= cnt;
                    best_mag  <= cand_mag;
                    best_tot  <= cand_tot;
                end
                if (cnt == '1) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    rd_q <= (win_tot > RD_HI) ? RD_W'(RD_HI)
                          : (win_tot < RD_LO) ? RD_W'(RD_LO) : RD_W'(win_tot);
                end
            end
        end
    end

    // R9
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !in_ready_o);

    // R11
    search_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    best_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt != '0) |=> best_mag <= $past(best_mag));
endmodule

// File: rtl/tern_sym_serializer.sv
// Sends one word as N_GROUPS+1 symbols: the mask first, then the masked groups,
// with flagged groups replaced by the quiet symbol. Loads the next word on its last symbol.
module tern_sym_serializer import tern_pkg::*; #(
    parameter int N_GROUPS  = 7,
    parameter int RUN_LIMIT = 2,
    localparam int WORD_W   = N_GROUPS*GRP_W - 1,
    localparam int IDX_W    = $clog2(N_GROUPS + 1),
    localparam int RUN_W    = $clog2(RUN_LIMIT + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                res_valid_i,
    output logic                res_take_o,
    input  logic [WORD_W-1:0]   res_word_i,
    input  logic [GRP_W-1:0]    res_mask_i,
    input  logic [N_GROUPS-1:0] res_rep_i,
    output logic                sym_valid_o,
    output logic                sym_first_o,
    output logic [3:0]          sym_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_GROUPS);

    logic                     active, load;
    logic [IDX_W-1:0]         idx, grp_idx;
    logic [WORD_W-1:0]        word_r;
    logic [GRP_W-1:0]         mask_r;
    logic [N_GROUPS-1:0]      rep_r;
    logic [N_GROUPS*GRP_W-1:0] pad;
    logic [GRP_W-1:0]         grp [N_GROUPS];
    logic [RUN_W-1:0]         quiet_run;

    assign pad = {word_r, 1'b0};

    for (genvar i = 0; i < N_GROUPS; i++) begin : g_split
        assign grp[i] = pad[(N_GROUPS-1-i)*GRP_W +: GRP_W];
    end

    assign res_take_o = !active || (idx == LAST);
    assign load       = res_valid_i && res_take_o;
    assign grp_idx    = idx - 1'b1;

    // Step through the symbols of the held word, reloading at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; idx <= '0; word_r <= '0; mask_r <= '0; rep_r <= '0;
        end else if (load) begin
            active <= 1'b1; idx <= '0;
            word_r <= res_word_i; mask_r <= res_mask_i; rep_r <= res_rep_i;
        end else if (active) begin
            if (idx == LAST) active <= 1'b0;
            else             idx    <= idx + 1'b1;
        end
    end

    // Pick the mask symbol, a masked group, or the quiet symbol.
    always_comb begin
        if (idx == '0)            sym_o = grp_symbol(mask_r);
        else if (rep_r[grp_idx])  sym_o = 4'b0000;
        else                      sym_o = grp_symbol(grp[grp_idx] ^ mask_r);
    end

    assign sym_valid_o = active;
    assign sym_first_o = active && (idx == '0);

    // Count consecutive quiet symbols on the line for the run-limit check.
    always_ff @(posedge clk) begin
        if (!rst_n)           quiet_run <= '0;
        else if (sym_valid_o) quiet_run <= (sym_o == 4'b0000) ? quiet_run + 1'b1 : '0;
    end

    // R6
    quiet_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_o && sym_o == 4'b0000) |-> (quiet_run < RUN_W'(RUN_LIMIT)));

    // R3
    mask_not_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_first_o |-> (sym_o != 4'b0000));

    // R1
    trit_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid_o |-> (sym_o[3:2] != 2'b11 && sym_o[1:0] != 2'b11));
endmodule

// File: rtl/tern_balance_enc.sv
// Top of the balanced ternary word encoder: mask search feeding a symbol serializer.
// Assumes a continuously ready line; symbols leave one per cycle while valid.
module tern_balance_enc import tern_pkg::*; #(
    parameter int N_GROUPS  = 7,
    parameter int RUN_LIMIT = 2,
    parameter int RD_W      = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      word_valid_i,
    input  logic [N_GROUPS*GRP_W-2:0] word_data_i,
    output logic                      word_ready_o,
    output logic                      sym_valid_o,
    output logic                      sym_first_o,
    output logic [3:0]                sym_o
);
    localparam int WORD_W = N_GROUPS*GRP_W - 1;

    logic                res_valid, res_take;
    logic [WORD_W-1:0]   res_word;
    logic [GRP_W-1:0]    res_mask;
    logic [N_GROUPS-1:0] res_rep;

    tern_mask_search #(.N_GROUPS(N_GROUPS), .RUN_LIMIT(RUN_LIMIT), .RD_W(RD_W)) search_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid_i(word_valid_i), .in_data_i(word_data_i), .in_ready_o(word_ready_o),
        .res_valid_o(res_valid), .res_take_i(res_take),
        .res_word_o(res_word), .res_mask_o(res_mask), .res_rep_o(res_rep));

    tern_sym_serializer #(.N_GROUPS(N_GROUPS), .RUN_LIMIT(RUN_LIMIT)) ser_i (
        .clk(clk), .rst_n(rst_n),
        .res_valid_i(res_valid), .res_take_o(res_take),
        .res_word_i(res_word), .res_mask_i(res_mask), .res_rep_i(res_rep),
        .sym_valid_o(sym_valid_o), .sym_first_o(sym_first_o), .sym_o(sym_o));

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!sym_valid_o && word_ready_o));
endmodule

// File: tb/tern_balance_enc_tb.sv
module tern_balance_enc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXS = 1024;
    localparam int RD_LIM = 31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [19:0] word_data_i = '0;
    logic        word_ready_o, sym_valid_o, sym_first_o;
    logic [3:0]  sym_o;

    int checks = 0, fails = 0;
    logic [3:0] exp_sym [MAXS];
    bit         exp_first [MAXS];
    logic [3:0] got_sym [MAXS];
    bit         got_first [MAXS];
    int exp_n = 0, got_n = 0;
    int rd_model = 0;
    bit finished = 1'b0;

    tern_balance_enc dut_i (
        .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid_i), .word_data_i(word_data_i),
        .word_ready_o(word_ready_o), .sym_valid_o(sym_valid_o),
        .sym_first_o(sym_first_o), .sym_o(sym_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Record every symbol away from the active edge.
    always @(negedge clk)
        if (rst_n && sym_valid_o && got_n < MAXS) begin
            got_sym[got_n] = sym_o;
            got_first[got_n] = sym_first_o;
            got_n++;
        end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    function automatic logic [3:0] m_sym(input logic [2:0] g);
        case (g)
            3'd0: return 4'b0100; 3'd1: return 4'b0001;
            3'd2: return 4'b1010; 3'd3: return 4'b0101;
            3'd4: return 4'b1000; 3'd5: return 4'b0010;
            3'd6: return 4'b0110; default: return 4'b1001;
        endcase
    endfunction

    function automatic int m_wt(input logic [2:0] g);
        case (g)
            3'd0, 3'd1: return -1; 3'd2: return 2; 3'd3: return -2;
            3'd4, 3'd5: return 1; default: return 0;
        endcase
    endfunction

    // Expected symbols of one word from the requirements; appends to exp_sym.
    task automatic model_word(input logic [19:0] d);
        logic [20:0] p = {d, 1'b0};
        logic [2:0] g [7];
        bit rep [7];
        int run = 0, best_m = 0, best_t = 0, best_a = 1000;
        for (int i = 0; i < 7; i++) g[i] = p[(6-i)*3 +: 3];
        rep[0] = 1'b0;
        for (int i = 1; i < 7; i++) begin
            if (g[i] == g[i-1] && run < 2) begin rep[i] = 1'b1; run++; end
            else begin rep[i] = 1'b0; run = 0; end
        end
        for (int m = 0; m < 8; m++) begin
            int t = rd_model;
            int a;
            for (int i = 0; i < 7; i++) if (!rep[i]) t += m_wt(g[i] ^ 3'(m));
            a = (t < 0) ? -t : t;
            if (a < best_a) begin best_a = a; best_m = m; best_t = t; end
        end
        rd_model = (best_t > RD_LIM) ? RD_LIM : (best_t < -RD_LIM) ? -RD_LIM : best_t;
        exp_sym[exp_n] = m_sym(3'(best_m)); exp_first[exp_n] = 1'b1; exp_n++;
        for (int i = 0; i < 7; i++) begin
            exp_sym[exp_n] = rep[i] ? 4'b0000 : m_sym(g[i] ^ 3'(best_m));
            exp_first[exp_n] = 1'b0;
            exp_n++;
        end
    endtask

    // Offer one word, called at a negedge; returns at the negedge after acceptance.
    task automatic send_word(input logic [19:0] d, input bit keep);
        word_valid_i = 1'b1;
        word_data_i = d;
        while (!word_ready_o) @(negedge clk);
        @(posedge clk);
        model_word(d);
        @(negedge clk);
        if (!keep) word_valid_i = 1'b0;
    endtask

    task automatic drain(input string tag, input int from);
        int w = 0;
        while (got_n < exp_n && w < 400) begin @(negedge clk); w++; end
        repeat (12) @(negedge clk);
        chk(got_n == exp_n, {tag, " symbol count"}, got_n, exp_n);
        for (int i = from; i < exp_n; i++) begin
            chk(got_sym[i] == exp_sym[i], {tag, " symbol"}, got_sym[i], exp_sym[i]);
            chk(got_first[i] == exp_first[i], {tag, " first marker R3"}, got_first[i], exp_first[i]);
        end
    endtask

    task automatic t_reset();
        // R10: idle outputs during reset
        chk(word_ready_o == 1'b1, "R10 ready in reset", word_ready_o, 1);
        chk(sym_valid_o == 1'b0, "R10 sym_valid in reset", sym_valid_o, 0);
    endtask

    task automatic t_ready_window();
        int from = exp_n;
        send_word(20'h5A3C1, 1'b0);
        for (int k = 0; k < 8; k++) begin
            chk(word_ready_o == 1'b0, "R9 ready low during search", word_ready_o, 0);
            @(negedge clk);
        end
        chk(word_ready_o == 1'b1, "R9 ready back after search", word_ready_o, 1);
        drain("R9 R1 R4", from);
    endtask

    task automatic t_mapping();
        int from = exp_n;
        // R2: lone LSB lands in the last group as 010; R1 R4 general mapping
        send_word(20'h00001, 1'b0);
        send_word(20'h80000, 1'b0);
        send_word(20'h2C6B5, 1'b0);
        send_word(20'hD1E97, 1'b0);
        drain("R1 R2 R4", from);
    endtask

    task automatic t_repeats();
        int from = exp_n;
        // R5 R6: all-equal groups give quiet, quiet, forced real, quiet, quiet, real
        send_word(20'h00000, 1'b0);
        send_word(20'hFFFFF, 1'b0);
        send_word(20'h92492, 1'b0);
        drain("R5 R6", from);
    endtask

    task automatic t_drift();
        int from = exp_n;
        // R7 R8: lopsided words push the carried disparity; ties pick the lower mask
        for (int k = 0; k < 6; k++) send_word(20'h4924C ^ 20'(k * 37), 1'b0);
        send_word(20'h00000, 1'b0);
        drain("R7 R8", from);
    endtask

    task automatic t_burst();
        int from = exp_n;
        // R11: valid held so acceptance and handoff share edges
        for (int k = 0; k < 6; k++) send_word(20'h13579 + 20'(k * 20'h0F0E1), k != 5);
        drain("R11", from);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog R11", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ready_window();
        t_mapping();
        t_repeats();
        t_drift();
        t_burst();
        finish_run();
    end
endmodule